// File: doc/BRIEF.md
# Character Terminal Transmit Register Interface

This block is the transmit side of a bus-mapped character terminal. It exposes two 16-bit words in a small address window: a control/status word carrying a ready flag and an interrupt enable, and a data word holding the character last loaded for output. Address bit 1 picks between the two words, and address bit 0 marks an odd-byte access.

Writing the data word starts a transmission. The block counts a programmable number of clock cycles per character and then offers the character downstream with a one-cycle valid strobe. If the downstream path signals a stall in that cycle, the block keeps the character and offers it again after another full interval. When the character is accepted, the ready flag comes back, and an interrupt is raised if it is enabled. Software clears the interrupt by disabling it or by writing the next character.

Top module: `tty_tx_regs`

## Requirements
- R1: After reset the status word reads 0x0080 (ready set, enable clear), the data word reads 0x0000, and `irq` and `tx_valid` are low.
- R2: With `bus_addr[1]`=0 a read returns the status word, where bit 7 is ready and bit 6 is interrupt enable and all other bits read 0. With `bus_addr[1]`=1 a read returns the buffered character in bits 7:0 and zeros above it.
- R3: A write to the status word with `bus_addr[0]`=0 updates only the enable bit from `bus_wdata[6]`. A status write with `bus_addr[0]`=1 leaves the enable bit and `irq` unchanged.
- R4: Writing enable=0 drops `irq` on the next edge. Writing enable=1 while ready is set and enable was clear raises `irq` on the next edge. `irq` is never high while ready is clear.
- R5: A write to the data word loads `bus_wdata[7:0]` into the buffer only when `bus_addr[0]`=0. Both byte forms clear ready and `irq` on the next edge and start a transmission.
- R6: With an interval of N cycles, `tx_valid` is high for one cycle, N-1 edges after the starting write edge, with `tx_char` equal to the buffer. If `tx_stall` is low in that cycle, ready is set on the next edge and `irq` rises with it if enable is set.
- R7: If `tx_stall` is high while `tx_valid` is high, ready stays clear, the character is held, and `tx_valid` comes back N edges later.
- R8: `char_cycles`=0 selects the parameter `DEFAULT_INTERVAL` as the interval.
- R9: A data write during a transmission restarts the full interval with the new character.
- R10: Reads of either word change neither ready, enable nor `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Bit 1 selects the word, bit 0 marks an odd byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, zero when `bus_en` is low |
| char_cycles | input | CNT_W | Cycles per character, 0 selects the default |
| tx_valid | output | 1 | Character offered downstream this cycle |
| tx_char | output | 8 | Character being sent |
| tx_stall | input | 1 | Downstream refuses the offered character |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the enable edge cases. A design that raised the interrupt on every enable write, or that honoured odd-byte status writes, would show `irq` or the enable bit flipping where it must hold. It also checks the odd-byte data write: a design that loaded the data anyway would read back the wrong character, and one that skipped the start would leave ready set. The exact cycle of the strobe and of ready is checked for the stalled case, the restarted case and the default-interval case, so an off-by-one counter, a lost retry or a timer that does not restart shows up as an early or a missing ready.

// File: rtl/tty_tx_pkg.sv
package tty_tx_pkg;
  localparam int WORD_W  = 16;
  localparam int CHAR_W  = 8;
  localparam int RDY_BIT = 7;
  localparam int IE_BIT  = 6;

  // Status word image: only the ready and enable bits are implemented.
  function automatic logic [WORD_W-1:0] pack_status(input logic rdy, input logic ie);
    logic [WORD_W-1:0] w;
    w = '0;
    w[RDY_BIT] = rdy;
    w[IE_BIT]  = ie;
    return w;
  endfunction

  // Zero on the programmed count means use the built-in default.
  function automatic logic [31:0] pick_interval(input logic [31:0] cfg, input logic [31:0] dflt);
    return (cfg == 32'd0) ? dflt : cfg;
  endfunction

  // Countdown start value for an interval of n cycles (n >= 1).
  function automatic logic [31:0] reload_of(input logic [31:0] n);
    return (n == 32'd0) ? 32'd0 : n - 32'd1;
  endfunction
endpackage

// File: rtl/tty_tx_decode.sv
module tty_tx_decode
  import tty_tx_pkg::*;
(
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic              status_wr,
  output logic              data_wr,
  output logic              data_load,
  output logic              wr_ie,
  output logic [CHAR_W-1:0] wr_char,
  output logic              rd_data_sel
);
  logic wr_any;
  logic unused_wbits;

  assign wr_any      = bus_en && bus_we;
  // Odd-byte status writes are dropped here.
  assign status_wr   = wr_any && !bus_addr[1] && !bus_addr[0];
  // Every data-word write starts a transmission; only even-byte ones load.
  assign data_wr     = wr_any && bus_addr[1];
  assign data_load   = data_wr && !bus_addr[0];
  assign wr_ie       = bus_wdata[IE_BIT];
  assign wr_char     = bus_wdata[CHAR_W-1:0];
  assign rd_data_sel = bus_addr[1];
  assign unused_wbits = ^{bus_wdata[WORD_W-1:CHAR_W], bus_wdata[RDY_BIT]};
endmodule

// File: rtl/tty_tx_timer.sv
module tty_tx_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] reload,
  input  logic             stall,
  output logic             busy,
  output logic             fire,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign busy = busy_q;
  assign fire = busy_q && (cnt_q == '0);
  assign done = fire && !stall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= reload;
    end else if (fire) begin
      if (stall) begin
        cnt_q <= reload;
      end else begin
        busy_q <= 1'b0;
      end
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/tty_tx_flags.sv
module tty_tx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic status_wr,
  input  logic wr_ie,
  input  logic data_wr,
  input  logic done,
  output logic ready,
  output logic ie,
  output logic irq
);
  logic rdy_q, ie_q, irq_q;
  logic rdy_n, ie_n, irq_n;

  always_comb begin
    rdy_n = rdy_q;
    ie_n  = ie_q;
    irq_n = irq_q;
    if (done) begin
      rdy_n = 1'b1;
      if (ie_q) irq_n = 1'b1;
    end
    if (status_wr) begin
      ie_n = wr_ie;
      if (!wr_ie)                irq_n = 1'b0;
      else if (rdy_n && !ie_q)   irq_n = 1'b1;
    end
    if (data_wr) begin
      rdy_n = 1'b0;
      irq_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q <= 1'b1;
      ie_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      rdy_q <= rdy_n;
      ie_q  <= ie_n;
      irq_q <= irq_n;
    end
  end

  assign ready = rdy_q;
  assign ie    = ie_q;
  assign irq   = irq_q;
endmodule

// File: rtl/tty_tx_regs.sv
module tty_tx_regs
  import tty_tx_pkg::*;
#(
  parameter int CNT_W            = 16,
  parameter int DEFAULT_INTERVAL = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  char_cycles,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_char,
  input  logic              tx_stall,
  output logic              irq
);
  localparam logic [31:0] DFLT = 32'(DEFAULT_INTERVAL);

  // Named internal events, also watched by the checker.
  logic              status_wr, data_wr, data_load, wr_ie, rd_data_sel;
  logic [CHAR_W-1:0] wr_char;
  logic              tx_busy, tx_fire, tx_done;
  logic              ready, ie;
  logic [CHAR_W-1:0] char_q;
  logic [31:0]       interval_full;
  logic [CNT_W-1:0]  reload;
  logic              unused_hi;

  tty_tx_decode u_dec (
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .status_wr(status_wr), .data_wr(data_wr), .data_load(data_load),
    .wr_ie(wr_ie), .wr_char(wr_char), .rd_data_sel(rd_data_sel)
  );

  assign interval_full = reload_of(pick_interval(32'(char_cycles), DFLT));
  assign reload        = interval_full[CNT_W-1:0];
  assign unused_hi     = ^interval_full;

  tty_tx_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(data_wr), .reload(reload),
    .stall(tx_stall), .busy(tx_busy), .fire(tx_fire), .done(tx_done)
  );

  tty_tx_flags u_flg (
    .clk(clk), .rst_n(rst_n), .status_wr(status_wr), .wr_ie(wr_ie),
    .data_wr(data_wr), .done(tx_done), .ready(ready), .ie(ie), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         char_q <= '0;
    else if (data_load) char_q <= wr_char;
  end

  assign tx_valid = tx_fire;
  assign tx_char  = char_q;

  always_comb begin
    if (!bus_en)          bus_rdata = '0;
    else if (rd_data_sel) bus_rdata = {{(WORD_W-CHAR_W){1'b0}}, char_q};
    else                  bus_rdata = pack_status(ready, ie);
  end
endmodule

// File: rtl/tty_tx_checker.sv
module tty_tx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       status_wr,
  input logic       wr_ie,
  input logic       data_wr,
  input logic       tx_fire,
  input logic       tx_stall,
  input logic       ready,
  input logic       ie,
  input logic       irq,
  input logic [7:0] tx_char
);
  assert_data_write_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> (!ready && !irq));

  assert_ready_on_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fire && !tx_stall && !data_wr) |=> ready);

  assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fire && tx_stall && !data_wr) |=> (!ready && $stable(tx_char)));

  assert_ie_clear_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_wr && !wr_ie && !data_wr) |=> !irq);

  assert_irq_needs_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ready);

  assert_ie_follows_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status_wr |=> (ie == $past(wr_ie)));

  assert_ie_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !status_wr |=> $stable(ie));
endmodule

bind tty_tx_regs tty_tx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .status_wr(status_wr), .wr_ie(wr_ie),
  .data_wr(data_wr), .tx_fire(tx_fire), .tx_stall(tx_stall),
  .ready(ready), .ie(ie), .irq(irq), .tx_char(tx_char)
);

// File: tb/tb_tty_tx_regs.sv
module tb_tty_tx_regs;
  localparam int CNT_W = 16;
  localparam int DFLT  = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic [CNT_W-1:0] char_cycles = 16'd5;
  logic        tx_valid;
  logic [7:0]  tx_char;
  logic        tx_stall = 1'b0;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tty_tx_regs #(.CNT_W(CNT_W), .DEFAULT_INTERVAL(DFLT)) dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .char_cycles(char_cycles), .tx_valid(tx_valid), .tx_char(tx_char),
    .tx_stall(tx_stall), .irq(irq)
  );

  // Table: {addr[1:0], wdata[15:0], expected status[15:0], expected irq}
  localparam int NV = 8;
  localparam logic [34:0] VEC [NV] = '{
    {2'd0, 16'h0040, 16'h00C0, 1'b1},  // R4 enable while ready raises irq
    {2'd0, 16'h0040, 16'h00C0, 1'b1},  // R4 re-enable keeps irq
    {2'd0, 16'hFFBF, 16'h0080, 1'b0},  // R3 R2 only enable written; R4 drop
    {2'd1, 16'h0040, 16'h0080, 1'b0},  // R3 odd byte ignored
    {2'd0, 16'h0040, 16'h00C0, 1'b1},  // R4
    {2'd2, 16'h1255, 16'h0040, 1'b0},  // R5 even data write
    {2'd0, 16'h0040, 16'h0040, 1'b0},  // R4 no raise while not ready
    {2'd3, 16'h00AA, 16'h0040, 1'b0}   // R5 odd data write still starts
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [15:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [15:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [15:0] r;
    do_reset();

    // R1 reset state
    do_read(2'd0, r); check("R1 status", r, 16'h0080);
    do_read(2'd2, r); check("R1 data", r, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 tx_valid", {15'd0, tx_valid}, 16'd0);

    // Table walk with a long interval so nothing completes.
    char_cycles = 16'd1000;
    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i][34:33], VEC[i][32:17]);
      do_read(2'd0, r);
      check($sformatf("R2 R3 R4 R5 vec%0d status", i), r, VEC[i][16:1]);
      check($sformatf("R4 R5 vec%0d irq", i), {15'd0, irq}, {15'd0, VEC[i][0]});
    end
    do_read(2'd2, r); check("R5 odd write keeps char", r, 16'h0055);
    do_reset();

    // R6 timing with interval 5 and enable set
    char_cycles = 16'd5;
    do_write(2'd0, 16'h0040);
    do_write(2'd2, 16'h0041);
    repeat (3) @(posedge clk);
    #1 check("R6 no early valid", {15'd0, tx_valid}, 16'd0);
    @(posedge clk); #1;
    check("R6 valid", {15'd0, tx_valid}, 16'd1);
    check("R6 char", {8'd0, tx_char}, 16'h0041);
    do_read(2'd0, r); check("R6 not ready yet", r, 16'h0040);
    @(posedge clk); #1;
    check("R6 valid one cycle", {15'd0, tx_valid}, 16'd0);
    do_read(2'd0, r); check("R6 ready", r, 16'h00C0);
    check("R6 irq", {15'd0, irq}, 16'd1);

    // R10 reads have no side effects
    repeat (3) begin do_read(2'd2, r); @(posedge clk); #1; end
    do_read(2'd0, r); check("R10 status after reads", r, 16'h00C0);
    check("R10 irq after reads", {15'd0, irq}, 16'd1);

    // R7 stall and retry
    tx_stall = 1'b1;
    do_write(2'd2, 16'h0033);
    repeat (4) @(posedge clk);
    #1 check("R7 first offer", {15'd0, tx_valid}, 16'd1);
    @(posedge clk); #1;
    do_read(2'd0, r); check("R7 stalled not ready", r, 16'h0040);
    check("R7 no irq while stalled", {15'd0, irq}, 16'd0);
    repeat (3) @(posedge clk);
    #1 check("R7 no early retry", {15'd0, tx_valid}, 16'd0);
    @(posedge clk); #1;
    check("R7 retry offer", {15'd0, tx_valid}, 16'd1);
    check("R7 char held", {8'd0, tx_char}, 16'h0033);
    tx_stall = 1'b0;
    @(posedge clk); #1;
    do_read(2'd0, r); check("R7 ready after accept", r, 16'h00C0);

    // R9 restart on write during transmission
    do_write(2'd2, 16'h0011);
    repeat (2) @(posedge clk);
    #1 do_write(2'd2, 16'h0022);
    repeat (3) @(posedge clk);
    #1 check("R9 no valid from first", {15'd0, tx_valid}, 16'd0);
    @(posedge clk); #1;
    check("R9 valid", {15'd0, tx_valid}, 16'd1);
    check("R9 new char", {8'd0, tx_char}, 16'h0022);
    @(posedge clk); #1;
    do_read(2'd0, r); check("R9 ready", r, 16'h00C0);

    // R8 default interval
    char_cycles = 16'd0;
    do_write(2'd2, 16'h0077);
    begin
      int edges = 0;
      for (int k = 1; k <= 50; k++) begin
        @(posedge clk); #1;
        do_read(2'd0, r);
        if (r[7] && edges == 0) edges = k;
      end
      check("R8 default interval", 16'(edges), 16'(DFLT));
    end

    finish_up();
  end
endmodule